// File: doc/BRIEF.md
# Add/Subtract Unit with Carry Held in the Program Counter

This block is the 16-bit add/subtract part of a small processor's execution stage. It adds, subtracts, compares unsigned and signed operands, and picks the smaller or larger of two operands under unsigned or signed ordering. The processor has no status register. Its single carry flag lives in bit 0 of the program counter. Instructions are 2-byte aligned, so that bit plays no part in addressing.

The unit owns the flag register. Each valid operation loads the flag on the clock edge, and the flag holds its value at every other time. The unit also merges the program counter. Other sources provide the current PC value or a load value, and only bits 15..1 of those take effect. Bit 0 of the merged PC is always the flag, so any instruction can read and test it.

The result and its write-enable are combinational and belong to the same cycle as the operands. The flag shows up on `pc_next[0]` after the clock edge that follows a valid operation.

Top module: `pcc_asu`

## Requirements
- R1: Operation codes on `op`: 0 = ADD, 1 = SUB, 2 = CMPU, 3 = CMPS, 4 = MIN, 5 = MAX, 6 = SMIN, 7 = SMAX. For ADD, `res` is `opa + opb` modulo 2^16, and the flag is loaded with the carry out of bit 15.
- R2: For SUB, `res` is `opa - opb` modulo 2^16, and the flag is loaded with the borrow, which is 1 exactly when `opa < opb` unsigned.
- R3: CMPU and CMPS never raise `res_we`. CMPU loads the flag with `opa < opb` unsigned. CMPS loads it with `opa < opb`, where both operands are read as two's-complement signed values.
- R4: Comparing an operand with an equal operand (CMPU or CMPS with `opa == opb`) clears the flag.
- R5: MIN returns the unsigned smaller operand and MAX the unsigned larger one. Both load the flag with `opa < opb` unsigned.
- R6: SMIN returns the signed smaller operand and SMAX the signed larger one. Both load the flag with `opa < opb` signed.
- R7: `res_we` is 1 only when `op_valid` is 1 and the code is ADD, SUB, MIN, MAX, SMIN or SMAX.
- R8: The flag changes only at a clock edge where `op_valid` is 1. It holds through idle cycles and through PC loads.
- R9: `pc_next[15:1]` equals `pc_ld_val[15:1]` when `pc_ld` is 1, and `pc_cur[15:1]` otherwise. `pc_next[0]` is always the flag, and bit 0 of `pc_cur` and of `pc_ld_val` has no effect.
- R10: While `rst_n` is low, the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the flag |
| op_valid | input | 1 | An operation is issued this cycle |
| op | input | 3 | Operation code |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| pc_cur | input | 16 | Current program counter |
| pc_ld | input | 1 | Another source writes the PC this cycle |
| pc_ld_val | input | 16 | PC value written by the other source |
| res | output | 16 | Operation result |
| res_we | output | 1 | Register write-enable for `res` |
| pc_next | output | 16 | Merged PC, with the flag in bit 0 |

## Verification
The bench targets the operand pairs whose order changes with signedness, such as 0x8000 against 0x0001. A design that mixed up the two orderings would return the wrong minimum or maximum and set the wrong flag under CMPS, SMIN or SMAX. A self-compare run right after an operation that set the flag checks the carry convention, since a design using the no-borrow convention would leave the flag set. The bench also drives PC loads with bit 0 set and runs idle cycles after the flag is set, so a design that let a PC write touch bit 0, or let the flag change with no valid operation, would fail.

// File: rtl/pcc_asu.sv
module pcc_asu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] pc_cur,
  input  logic         pc_ld,
  input  logic [W-1:0] pc_ld_val,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic [W-1:0] pc_next
);
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_SUB  = 3'd1;
  localparam logic [2:0] OP_CMPU = 3'd2;
  localparam logic [2:0] OP_CMPS = 3'd3;
  localparam logic [2:0] OP_MIN  = 3'd4;
  localparam logic [2:0] OP_MAX  = 3'd5;
  localparam logic [2:0] OP_SMIN = 3'd6;
  localparam logic [2:0] OP_SMAX = 3'd7;

  logic [W:0]   sum, dif;
  logic         signed_op, lt, c_d, flag_q;
  logic         unused_bits;

  assign sum       = {1'b0, opa} + {1'b0, opb};
  assign dif       = {1'b0, opa} - {1'b0, opb};
  assign signed_op = (op == OP_CMPS) || (op == OP_SMIN) || (op == OP_SMAX);
  assign lt        = signed_op ? ($signed(opa) < $signed(opb)) : dif[W];

  always_comb begin
    res = dif[W-1:0];
    c_d = lt;
    case (op)
      OP_ADD:  begin res = sum[W-1:0]; c_d = sum[W]; end
      OP_MIN,
      OP_SMIN: res = lt ? opa : opb;
      OP_MAX,
      OP_SMAX: res = lt ? opb : opa;
      default: ;
    endcase
  end

  assign res_we = op_valid && (op != OP_CMPU) && (op != OP_CMPS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag_q <= 1'b0;
    else if (op_valid) flag_q <= c_d;

  assign pc_next     = {pc_ld ? pc_ld_val[W-1:1] : pc_cur[W-1:1], flag_q};
  assign unused_bits = pc_cur[0] ^ pc_ld_val[0] ^ (OP_SUB == 3'd1);
endmodule

// File: rtl/pcc_asu_chk.sv
module pcc_asu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] pc_cur,
  input logic         pc_ld,
  input logic [W-1:0] pc_ld_val,
  input logic [W-1:0] res,
  input logic         res_we,
  input logic [W-1:0] pc_next
);
  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 || op == 3'd3) |-> !res_we);

  assert_self_cmp_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == 3'd2 || op == 3'd3) && opa == opb) |=> !pc_next[0]);

  assert_umin_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4) |-> (res <= opa && res <= opb));

  assert_umax_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5) |-> (res >= opa && res >= opb));

  assert_smin_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd6) |-> ($signed(res) <= $signed(opa) && $signed(res) <= $signed(opb)));

  assert_idle_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !res_we);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(pc_next[0]));

  assert_pc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld |-> (pc_next[W-1:1] == pc_ld_val[W-1:1]));
endmodule

bind pcc_asu pcc_asu_chk #(.W(W)) u_chk (.*);

// File: tb/pcc_asu_tb.sv
module pcc_asu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] opa = '0, opb = '0, pc_cur = '0, pc_ld_val = '0;
  logic        pc_ld = 1'b0;
  logic [15:0] res, pc_next;
  logic        res_we;
  int          n_chk = 0, n_bad = 0;
  logic        flag = 1'b0;

  always #2.5 clk = ~clk;

  pcc_asu u_dut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] code, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] exp_res, input logic exp_we, input logic exp_c,
                        input string tag);
    @(negedge clk);
    op = code; opa = a; opb = b; op_valid = 1'b1;
    #1;
    if (exp_we) check({tag, " res"}, res, exp_res);
    check({tag, " res_we"}, {15'd0, res_we}, {15'd0, exp_we});
    @(negedge clk);
    op_valid = 1'b0;
    #1;
    check({tag, " flag"}, {15'd0, pc_next[0]}, {15'd0, exp_c});
    flag = exp_c;
  endtask

  task automatic t_reset;
    check("R10 reset flag", {15'd0, pc_next[0]}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R10 flag after release", {15'd0, pc_next[0]}, 16'd0);
  endtask

  task automatic t_add;
    run_op(3'd0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, "R1 add wrap");
    run_op(3'd0, 16'h0003, 16'h0004, 16'h0007, 1'b1, 1'b0, "R1 add small");
  endtask

  task automatic t_sub;
    run_op(3'd1, 16'h0005, 16'h0007, 16'hFFFE, 1'b1, 1'b1, "R2 sub borrow");
    run_op(3'd1, 16'h0007, 16'h0005, 16'h0002, 1'b1, 1'b0, "R2 sub no borrow");
  endtask

  task automatic t_cmp;
    run_op(3'd2, 16'h8000, 16'h0001, 16'h0000, 1'b0, 1'b0, "R3 cmpu");
    run_op(3'd3, 16'h8000, 16'h0001, 16'h0000, 1'b0, 1'b1, "R3 cmps");
    run_op(3'd3, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b0, "R4 cmps self");
    run_op(3'd1, 16'h0000, 16'h0001, 16'hFFFF, 1'b1, 1'b1, "R2 set flag");
    run_op(3'd2, 16'hBEEF, 16'hBEEF, 16'h0000, 1'b0, 1'b0, "R4 cmpu self");
  endtask

  task automatic t_minmax;
    run_op(3'd4, 16'h8000, 16'h0001, 16'h0001, 1'b1, 1'b0, "R5 min");
    run_op(3'd5, 16'h0001, 16'h8000, 16'h8000, 1'b1, 1'b1, "R5 max");
    run_op(3'd6, 16'h8000, 16'h0001, 16'h8000, 1'b1, 1'b1, "R6 smin");
    run_op(3'd7, 16'h8000, 16'h0001, 16'h0001, 1'b1, 1'b1, "R6 smax");
    run_op(3'd7, 16'h0005, 16'hFFFB, 16'h0005, 1'b1, 1'b0, "R6 smax neg");
  endtask

  task automatic t_idle;
    run_op(3'd0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1, "R1 add carry set");
    @(negedge clk);
    op = 3'd2; opa = 16'h0; opb = 16'h0; op_valid = 1'b0;
    #1 check("R7 idle res_we", {15'd0, res_we}, 16'd0);
    repeat (3) @(negedge clk);
    #1 check("R8 flag held idle", {15'd0, pc_next[0]}, {15'd0, flag});
  endtask

  task automatic t_pc;
    @(negedge clk);
    pc_cur = 16'h1235; pc_ld = 1'b0; pc_ld_val = 16'h00FF;
    #1 check("R9 pc pass", pc_next, {15'h091A, flag});
    pc_ld = 1'b1;
    #1 check("R9 pc load", pc_next, {15'h007F, flag});
    @(negedge clk);
    #1 check("R8 flag kept over load", {15'd0, pc_next[0]}, {15'd0, flag});
    pc_ld = 1'b0; pc_cur = 16'h4000;
    run_op(3'd1, 16'h0009, 16'h0009, 16'h0000, 1'b1, 1'b0, "R2 sub equal");
    check("R9 pc bit0 from flag", pc_next, 16'h4000);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset;
    t_add;
    t_sub;
    t_cmp;
    t_minmax;
    t_idle;
    t_pc;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule